// File: doc/BRIEF.md
# SPI Flash Phased Command Engine

This block is a single-lane SPI master (mode 0) that runs one serial-flash transaction per start strobe. A transaction is built from up to five phases, always in this sequence:

1. an 8-bit opcode;
2. an address of programmable length;
3. dummy clocks;
4. outgoing write data of up to 32 bits;
5. incoming read data of up to 32 bits.

Every phase other than the opcode is present only when its length is non-zero. The engine owns the clock, chip-select, data-out and write-protect pins. It samples the data-in pin and returns a masked 32-bit read word together with a one-cycle completion pulse.

A caller sets the request fields and pulses `start` while the engine is idle. The caller then waits for `done` and takes `rdWord`. Typical uses are a plain opcode (write disable), an identification read (opcode, then 24 read bits), and a discoverable-parameter-table read (opcode 0x5A, 24-bit address, 8 dummy clocks, 1 to 4 bytes).

Dummy clocks are spent only when the request reads data. Their number is the per-request dummy length plus a board-level extra count, which covers the added pin delay when the flash pins are routed through a pin multiplexer.

Top module: `spi_phase_engine`

## Requirements
- R1: The opcode phase is always sent first, as 8 bits of `cmdByte`, bit 7 first. Each serial bit takes two clocks: `sclk` low for one clock, then high for one clock. `mosi` changes only while `sclk` is low, and `miso` is sampled on the clock where `sclk` rises.
- R2: The address phase sends `addrLen` bits, starting with `addrVal[addrLen-1]` and ending with bit 0. It is skipped when `addrLen` is 0, and values above 32 act as 32.
- R3: When `rdLen` is non-zero, the address phase is followed by `dummyLen + extraDummy` dummy bits with `mosi` low. When `rdLen` is zero, or when that sum is zero, no dummy bits are sent.
- R4: The write phase sends `wrLen` bits, starting with `wrData[wrLen-1]`. It is skipped when `wrLen` is 0, and values above 32 act as 32. `mosi` is low during the read phase.
- R5: The read phase collects `rdLen` bits (values above 32 act as 32). Received bit k is stored at `rdWord` bit 8*(k/8) + 7 - (k mod 8). Each byte is therefore filled MSB first, and the first byte lands in bits 7:0.
- R6: When the read length is below 32, every `rdWord` bit at or above the read length reads 0. `rdWord` holds its value until the next accepted start and is 0 after reset.
- R7: `csN` falls on the clock edge that accepts `start`, one clock before the first rising `sclk`. It rises one clock after the last falling `sclk`, so it stays low for 2N+1 clocks for N serial bits. `done` is high for exactly that one cycle when `csN` returns high.
- R8: A `start` that arrives while `busy` is high is ignored. The running transaction, its pin activity and its result are unchanged by it.
- R9: `wp` is high at all times, including throughout every transaction.
- R10: After reset, `csN` is high, `sclk`, `mosi`, `busy` and `done` are low, and `rdWord` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock; `sclk` runs at half this rate |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction; ignored while busy |
| cmdByte | input | 8 | Opcode |
| addrLen | input | 6 | Address length in bits, 0 to skip |
| addrVal | input | 32 | Address, right-aligned |
| dummyLen | input | 8 | Requested dummy clocks |
| extraDummy | input | 4 | Board-level extra dummy clocks, added when reading |
| wrLen | input | 6 | Write length in bits, 0 to skip |
| wrData | input | 32 | Write data, right-aligned |
| rdLen | input | 6 | Read length in bits, 0 to skip |
| miso | input | 1 | Serial data from flash |
| sclk | output | 1 | Serial clock, idle low |
| csN | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to flash |
| wp | output | 1 | Write-protect pin, held high |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdWord | output | 32 | Masked read result |

## Verification
The in-RTL assertions check the following properties on every cycle:
- the pin discipline: `sclk` high for single clocks only, `mosi` steady while `sclk` is high, no clock while deselected, and the first rising edge one clock after select;
- that `done` is a lone pulse coinciding with deselect;
- that read samples never exceed the latched read length;
- that the latched request does not move while busy.

Only the bench scenarios can show the following behaviours, which it checks against a bit-level slave model:
- the exact serial bit order of each phase;
- dummy insertion depending on the read length;
- length clamping;
- byte-lane placement and masking of read data;
- the 2N+1 select width;
- that a start during a transaction leaves the result untouched.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  // Phase order is behaviour: the engine walks these upward, skipping empty ones.
  typedef enum logic [2:0] {
    PH_CMD   = 3'd0,
    PH_ADDR  = 3'd1,
    PH_DUMMY = 3'd2,
    PH_WR    = 3'd3,
    PH_RD    = 3'd4,
    PH_NONE  = 3'd5
  } phase_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic   load;    // capture the request bundle
    logic   sample;  // take one miso bit on this edge
    logic   busy;    // transaction in progress
    phase_e phase;   // current serial phase
  } strobe_s;
endpackage

// File: rtl/spi_eng_datapath.sv
module spi_eng_datapath
  import spi_eng_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 6,
  parameter int DUMMY_W = 8,
  parameter int EXTRA_W = 4,
  parameter int CNT_W   = DUMMY_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_s            stb,
  input  logic [CNT_W-1:0]   bitIdx,
  input  logic [7:0]         cmdByte,
  input  logic [LEN_W-1:0]   addrLen,
  input  logic [DATA_W-1:0]  addrVal,
  input  logic [DUMMY_W-1:0] dummyLen,
  input  logic [EXTRA_W-1:0] extraDummy,
  input  logic [LEN_W-1:0]   wrLen,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [LEN_W-1:0]   rdLen,
  input  logic               miso,
  output logic               mosi,
  output logic [DATA_W-1:0]  rdWord,
  output logic [LEN_W-1:0]   aLenOut,
  output logic [LEN_W-1:0]   wLenOut,
  output logic [LEN_W-1:0]   rLenOut,
  output logic [CNT_W-1:0]   dumTotal
);
  localparam int SEL_W = $clog2(DATA_W);

  logic [7:0]        cmdQ;
  logic [DATA_W-1:0] addrQ, wrQ, rdBuf;
  logic [LEN_W-1:0]  aLenQ, wLenQ, rLenQ;
  logic [CNT_W-1:0]  dumQ;
  logic [SEL_W-1:0]  rdCnt;
  logic [SEL_W-1:0]  rdPos;
  logic [LEN_W-1:0]  rLenIn;

  function automatic logic [LEN_W-1:0] clampLen(input logic [LEN_W-1:0] v);
    return (v > LEN_W'(DATA_W)) ? LEN_W'(DATA_W) : v;
  endfunction

  assign rLenIn = clampLen(rdLen);
  // Byte lanes ascend, bits within a lane arrive MSB first.
  assign rdPos  = {rdCnt[SEL_W-1:3], ~rdCnt[2:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ  <= '0;
      addrQ <= '0;
      wrQ   <= '0;
      aLenQ <= '0;
      wLenQ <= '0;
      rLenQ <= '0;
      dumQ  <= '0;
      rdBuf <= '0;
      rdCnt <= '0;
    end else if (stb.load) begin
      cmdQ  <= cmdByte;
      addrQ <= addrVal;
      wrQ   <= wrData;
      aLenQ <= clampLen(addrLen);
      wLenQ <= clampLen(wrLen);
      rLenQ <= rLenIn;
      dumQ  <= (rLenIn != '0) ? (CNT_W'(dummyLen) + CNT_W'(extraDummy)) : '0;
      rdBuf <= '0;
      rdCnt <= '0;
    end else if (stb.sample) begin
      rdBuf[rdPos] <= miso;
      rdCnt        <= rdCnt + 1'b1;
    end
  end

  always_comb begin
    unique case (stb.phase)
      PH_CMD:  mosi = cmdQ[bitIdx[2:0]];
      PH_ADDR: mosi = addrQ[bitIdx[SEL_W-1:0]];
      PH_WR:   mosi = wrQ[bitIdx[SEL_W-1:0]];
      default: mosi = 1'b0;
    endcase
  end

  always_comb begin
    if (rLenQ >= LEN_W'(DATA_W)) rdWord = rdBuf;
    else                         rdWord = rdBuf & ~({DATA_W{1'b1}} << rLenQ);
  end

  assign aLenOut  = aLenQ;
  assign wLenOut  = wLenQ;
  assign rLenOut  = rLenQ;
  assign dumTotal = dumQ;

  // R8: the captured request stays put for the whole transaction.
  assert_req_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.busy |=> $stable({cmdQ, addrQ, wrQ, aLenQ, wLenQ, rLenQ, dumQ}));

  // R5: control never asks for more read samples than the latched length.
  assert_sample_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.sample |-> ((LEN_W + 1)'(rdCnt) < (LEN_W + 1)'(rLenQ)));
endmodule

// File: rtl/spi_eng_ctrl.sv
module spi_eng_ctrl
  import spi_eng_pkg::*;
#(
  parameter int LEN_W = 6,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] aLen,
  input  logic [LEN_W-1:0] wLen,
  input  logic [LEN_W-1:0] rLen,
  input  logic [CNT_W-1:0] dumTotal,
  output strobe_s          stb,
  output logic [CNT_W-1:0] bitIdx,
  output logic             sclk,
  output logic             csN,
  output logic             done
);
  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH, ST_TAIL} state_e;

  state_e           state;
  phase_e           phaseQ;
  logic [CNT_W-1:0] idxQ;
  phase_e           nxtPh;
  logic [CNT_W-1:0] nxtLen;
  logic [4:0]       phEn;

  // Find the first non-empty phase after the current one.
  always_comb begin
    phEn           = '0;
    phEn[PH_ADDR]  = (aLen != '0);
    phEn[PH_DUMMY] = (dumTotal != '0);
    phEn[PH_WR]    = (wLen != '0);
    phEn[PH_RD]    = (rLen != '0);
    nxtPh = PH_NONE;
    for (int p = 4; p >= 1; p--) begin
      if (p > int'(phaseQ) && phEn[p]) nxtPh = phase_e'(3'(p));
    end
    unique case (nxtPh)
      PH_ADDR:  nxtLen = CNT_W'(aLen);
      PH_DUMMY: nxtLen = dumTotal;
      PH_WR:    nxtLen = CNT_W'(wLen);
      PH_RD:    nxtLen = CNT_W'(rLen);
      default:  nxtLen = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      phaseQ <= PH_NONE;
      idxQ   <= '0;
      sclk   <= 1'b0;
      csN    <= 1'b1;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state  <= ST_LOW;
          csN    <= 1'b0;
          phaseQ <= PH_CMD;
          idxQ   <= CNT_W'(7);
        end
        ST_LOW: begin
          sclk  <= 1'b1;
          state <= ST_HIGH;
        end
        ST_HIGH: begin
          sclk <= 1'b0;
          if (idxQ != '0) begin
            idxQ  <= idxQ - 1'b1;
            state <= ST_LOW;
          end else if (nxtPh != PH_NONE) begin
            phaseQ <= nxtPh;
            idxQ   <= nxtLen - 1'b1;
            state  <= ST_LOW;
          end else begin
            phaseQ <= PH_NONE;
            state  <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          csN   <= 1'b1;
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign stb.load   = (state == ST_IDLE) && start;
  assign stb.sample = (state == ST_LOW) && (phaseQ == PH_RD);
  assign stb.busy   = (state != ST_IDLE);
  assign stb.phase  = phaseQ;
  assign bitIdx     = idxQ;

  // R1: every high half of sclk lasts exactly one clock.
  assert_sclk_one_R1: assert property (@(posedge clk) disable iff (!rstN)
    sclk |=> !sclk);

  // R7: no serial clock while deselected.
  assert_idle_pins_R7: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  // R7: first rising sclk one clock after select.
  assert_cs_lead_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |=> $rose(sclk));

  // R7: done is a lone pulse, coincident with deselect.
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_cs_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> done);
endmodule

// File: rtl/spi_phase_engine.sv
module spi_phase_engine
  import spi_eng_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DUMMY_W = 8,
  parameter int EXTRA_W = 4,
  parameter int LEN_W   = $clog2(DATA_W + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [7:0]         cmdByte,
  input  logic [LEN_W-1:0]   addrLen,
  input  logic [DATA_W-1:0]  addrVal,
  input  logic [DUMMY_W-1:0] dummyLen,
  input  logic [EXTRA_W-1:0] extraDummy,
  input  logic [LEN_W-1:0]   wrLen,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [LEN_W-1:0]   rdLen,
  input  logic               miso,
  output logic               sclk,
  output logic               csN,
  output logic               mosi,
  output logic               wp,
  output logic               busy,
  output logic               done,
  output logic [DATA_W-1:0]  rdWord
);
  localparam int SUM_W = ((DUMMY_W > EXTRA_W) ? DUMMY_W : EXTRA_W) + 1;
  localparam int CNT_W = (SUM_W > LEN_W) ? SUM_W : LEN_W;

  strobe_s          stb;
  logic [CNT_W-1:0] bitIdx;
  logic [LEN_W-1:0] aLen, wLen, rLen;
  logic [CNT_W-1:0] dumTotal;

  spi_eng_ctrl #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .aLen(aLen), .wLen(wLen), .rLen(rLen), .dumTotal(dumTotal),
    .stb(stb), .bitIdx(bitIdx), .sclk(sclk), .csN(csN), .done(done)
  );

  spi_eng_datapath #(
    .DATA_W(DATA_W), .LEN_W(LEN_W), .DUMMY_W(DUMMY_W),
    .EXTRA_W(EXTRA_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .bitIdx(bitIdx),
    .cmdByte(cmdByte), .addrLen(addrLen), .addrVal(addrVal),
    .dummyLen(dummyLen), .extraDummy(extraDummy),
    .wrLen(wrLen), .wrData(wrData), .rdLen(rdLen), .miso(miso),
    .mosi(mosi), .rdWord(rdWord),
    .aLenOut(aLen), .wLenOut(wLen), .rLenOut(rLen), .dumTotal(dumTotal)
  );

  assign busy = stb.busy;
  assign wp   = 1'b1;  // R9: write protect never asserted by this engine

  // R1: data out holds still across each high half of sclk.
  assert_mosi_stable_R1: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> $stable(mosi));
endmodule

// File: tb/spi_phase_engine_tb.sv
module spi_phase_engine_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [7:0] cmdByte = '0;
  logic [5:0] addrLen = '0, wrLen = '0, rdLen = '0;
  logic [31:0] addrVal = '0, wrData = '0;
  logic [7:0] dummyLen = '0;
  logic [3:0] extraDummy = '0;
  logic miso = 1'b0;
  logic sclk, csN, mosi, wp, busy, done;
  logic [31:0] rdWord;

  int nChk = 0, nFail = 0;
  logic [511:0] misoPat, mosiLog, expBits;
  int riseCnt = 0, lowCnt = 0;
  bit wpBad = 1'b0;

  always #2 clk = ~clk;

  spi_phase_engine u_dut (
    .clk(clk), .rstN(rstN), .start(start), .cmdByte(cmdByte),
    .addrLen(addrLen), .addrVal(addrVal), .dummyLen(dummyLen),
    .extraDummy(extraDummy), .wrLen(wrLen), .wrData(wrData), .rdLen(rdLen),
    .miso(miso), .sclk(sclk), .csN(csN), .mosi(mosi), .wp(wp),
    .busy(busy), .done(done), .rdWord(rdWord)
  );

  // Bit-level flash model: present pattern bit j before rising edge j.
  always @(negedge csN) begin riseCnt = 0; miso = misoPat[0]; end
  always @(posedge sclk) begin
    if (riseCnt < 512) mosiLog[riseCnt] = mosi;
    riseCnt++;
  end
  always @(negedge sclk) if (!csN && riseCnt < 512) miso = misoPat[riseCnt];
  always @(negedge clk) begin
    if (!csN) lowCnt++;
    if (!wp) wpBad = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic runTxn(input logic [7:0] c, input int aL, input logic [31:0] aV,
                        input int dL, input int ex, input int wL, input logic [31:0] wD,
                        input int rL, input bit poke, input string tag);
    int aC = (aL > 32) ? 32 : aL;
    int wC = (wL > 32) ? 32 : wL;
    int rC = (rL > 32) ? 32 : rL;
    int n = 0, bad = 0, wait_ = 0;
    logic [31:0] expRd = '0;
    for (int i = 0; i < 16; i++) misoPat[i*32 +: 32] = $urandom;
    expBits = '0;
    for (int i = 7; i >= 0; i--) begin expBits[n] = c[i]; n++; end
    for (int i = aC - 1; i >= 0; i--) begin expBits[n] = aV[i]; n++; end
    if (rC > 0) n += dL + ex;
    for (int i = wC - 1; i >= 0; i--) begin expBits[n] = wD[i]; n++; end
    for (int k = 0; k < rC; k++) begin
      int pos = 8 * (k / 8) + 7 - (k % 8);
      if (pos < rC) expRd[pos] = misoPat[n + k];
    end
    n += rC;
    @(negedge clk);
    cmdByte = c; addrLen = 6'(aL); addrVal = aV; dummyLen = 8'(dL);
    extraDummy = 4'(ex); wrLen = 6'(wL); wrData = wD; rdLen = 6'(rL);
    start = 1'b1; lowCnt = 0; wpBad = 1'b0;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      chk(busy, "R8", "busy before poke", 64'(busy), 1);
      cmdByte = ~c; addrLen = 6'd0; rdLen = 6'd0; wrLen = 6'd32; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && wait_ < 4000) begin @(negedge clk); wait_++; end
    chk(done, "R7", {tag, " done seen"}, 64'(done), 1);
    chk(riseCnt == n, "R2 R3 R4", {tag, " serial bit count"}, 64'(riseCnt), 64'(n));
    for (int i = 0; i < n && i < 512; i++) if (mosiLog[i] !== expBits[i]) bad++;
    chk(bad == 0, "R1 R2 R3 R4", {tag, " mosi mismatches"}, 64'(bad), 0);
    chk(lowCnt == 2 * n + 1, "R7", {tag, " csN low clocks"}, 64'(lowCnt), 64'(2 * n + 1));
    chk(rdWord === expRd, "R5 R6", {tag, " rdWord"}, 64'(rdWord), 64'(expRd));
    chk(!wpBad, "R9", {tag, " wp high"}, 64'(wpBad), 0);
    @(negedge clk);
    chk(!done && csN, "R7", {tag, " done one cycle"}, 64'(done), 0);
    chk(rdWord === expRd, "R6", {tag, " rdWord held"}, 64'(rdWord), 64'(expRd));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL R7 watchdog expired: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    misoPat = '0; mosiLog = '0; expBits = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(csN === 1'b1, "R10", "csN reset", 64'(csN), 1);
    chk(sclk === 1'b0 && mosi === 1'b0, "R10", "sclk/mosi reset", 64'({sclk, mosi}), 0);
    chk(busy === 1'b0 && done === 1'b0, "R10", "busy/done reset", 64'({busy, done}), 0);
    chk(rdWord === 32'h0, "R10", "rdWord reset", 64'(rdWord), 0);
    chk(wp === 1'b1, "R9", "wp reset", 64'(wp), 1);
    rstN = 1'b1;
    @(negedge clk);
    chk(csN === 1'b1 && busy === 1'b0, "R10", "idle after reset", 64'({csN, busy}), 2);

    runTxn(8'h04, 0, 0, 0, 0, 0, 0, 0, 0, "R1 bare opcode");
    runTxn(8'h5A, 24, 32'h10, 8, 0, 0, 0, 8, 0, "R5 table one byte");
    runTxn(8'h5A, 24, 32'h30, 8, 2, 0, 0, 32, 0, "R3 table four bytes extra");
    runTxn(8'h9F, 0, 0, 0, 0, 0, 0, 24, 0, "R5 id read");
    runTxn(8'h0B, 8, 32'hA5, 3, 1, 0, 0, 12, 0, "R6 partial byte");
    runTxn(8'h02, 16, 32'hBEEF, 5, 3, 20, 32'hF0F0F, 0, 0, "R3 no read no dummy");
    runTxn(8'h03, 24, 32'h123456, 0, 0, 0, 0, 16, 0, "R3 zero dummy");
    runTxn(8'hC7, 40, 32'hDEADBEEF, 0, 0, 50, 32'h8000_0001, 45, 0, "R2 R4 clamp");
    runTxn(8'h01, 0, 0, 0, 0, 32, 32'hCAFE_F00D, 1, 0, "R4 full write");
    runTxn(8'h35, 8, 32'h5A, 2, 0, 8, 32'h3C, 32, 1, "R8 start while busy");

    for (int t = 0; t < 40; t++) begin
      int aL = int'($urandom_range(0, 4)) * 8;
      if ($urandom_range(0, 3) == 0) aL = int'($urandom_range(0, 32));
      runTxn(8'($urandom), aL, $urandom, int'($urandom_range(0, 15)),
             int'($urandom_range(0, 3)), int'($urandom_range(0, 32)), $urandom,
             int'($urandom_range(0, 32)), 0, "R5 random");
    end

    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule